// File: doc/BRIEF.md
# Banked Stack Pointer Special-Register Unit

This block holds the special-purpose registers of a small microcontroller-class core. It stores two stack pointers, main and process, as a pair: one active and one banked. Only the active one is visible on the general-register port. One bit of the control word selects the stack. Whenever that bit changes, the pair is exchanged in the same clock edge. The stored bit is therefore always the true selection, and a read of the control word never returns a stale copy.

A register-move port reads and writes the registers by special-register number. Reads are combinational. Writes take effect at the next rising edge. Exception-entry and exception-return strobes change the stack selection. While the entry strobe is high, the block presents the return-link value for the handler. The block also holds the interrupt-mask bit and the base-priority register.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, the control word, the interrupt mask and the base priority read 0. Reading number 8 and the general-register port both return `sp_reset_val`. Reading number 9 returns 0.
- R2: The control word has npriv at bit 0, stack-select at bit 1 and FP-context-active at bit 2. Reading number 8 (main SP) returns the active pointer when stack-select is 0 and the banked pointer when it is 1. Reading number 9 (process SP) does the opposite.
- R3: A register-move write to number 8 or 9 updates the main or process pointer under the same selection rule and leaves the other pointer unchanged.
- R4: A write to number 20 (control word) stores only bits 0 and 1, so bit 2 reads 0. When the written stack-select differs from the stored one, the active and banked pointers are exchanged at the same edge.
- R5: `gp_sp_rdata` always shows the active pointer. `gp_sp_we` writes the active pointer.
- R6: While `exc_entry` is high, `link_out` equals 0xFFFFFFF1. Bit 2 is set if stack-select is 1, and bit 3 is set if `exc_handler` is 0 (thread mode).
- R7: Exception entry clears stack-select and keeps npriv. After entry, number 20 reads the cleared bit and the main pointer becomes active.
- R8: Exception return loads stack-select from bit 2 of `exc_ret_link` and swaps the pointers if the value changes.
- R9: Number 16 reads 1 when the interrupt mask is set. A write sets the mask when bit 0 of the data is 1 and clears it when bit 0 is 0. All other bits are ignored.
- R10: Number 17 reads the BP_W-bit base priority, zero-extended. A write stores the low BP_W data bits.
- R11: When an exception strobe and a control-word write fall in the same cycle, the control-word write is dropped entirely and the exception update applies. If entry and return are both high, entry wins.
- R12: Any number other than 8, 9, 16, 17 or 20 reads 0, and a write to it changes no register. For each such access, `mv_err` is high for exactly the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_reset_val | input | W | Main SP value loaded at reset |
| mv_valid | input | 1 | Register-move access this cycle |
| mv_write | input | 1 | 1 = write, 0 = read |
| mv_num | input | NUM_W | Special-register number |
| mv_wdata | input | W | Register-move write data |
| mv_rdata | output | W | Register-move read data (combinational) |
| mv_err | output | 1 | Unknown-number pulse, one cycle after the access |
| gp_sp_we | input | 1 | General-register write of the active SP |
| gp_sp_wdata | input | W | General-register write data |
| gp_sp_rdata | output | W | Active stack pointer |
| exc_entry | input | 1 | Exception-entry strobe |
| exc_handler | input | 1 | 1 when an exception is already active |
| exc_return | input | 1 | Exception-return strobe |
| exc_ret_link | input | W | Return-link value used on return |
| link_out | output | 32 | Return-link value for entry |

## Verification
A wrong stack-select bit appears at once on `gp_sp_rdata` and in reads of numbers 8, 9 and 20 in the cycle after the update. The bench therefore checks the pointer and the control word together after each entry, return and control write. A missed or doubled swap shows as the main and process values trading places. Seeding the two pointers with distinct values makes such a swap visible in the first read that follows. A stale selection also shows combinationally on bit 2 of `link_out` during the next entry.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int SR_MSP     = 8;
  localparam int SR_PSP     = 9;
  localparam int SR_PRIMASK = 16;
  localparam int SR_BASEPRI = 17;
  localparam int SR_CONTROL = 20;

  localparam int CTL_NPRIV = 0;
  localparam int CTL_SPSEL = 1;
  localparam int CTL_FPCA  = 2;

  localparam int LINK_W = 32;
  localparam logic [LINK_W-1:0] LINK_BASE = 32'hFFFF_FFF1;

  function automatic logic [LINK_W-1:0] link_value(input logic sel, input logic handler);
    logic [LINK_W-1:0] v;
    v    = LINK_BASE;
    v[2] = sel;
    v[3] = ~handler;
    return v;
  endfunction
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl #(
  parameter int BP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_entry,
  input  logic            exc_return,
  input  logic            ret_sel,
  input  logic            ctl_we,
  input  logic [1:0]      ctl_wbits,
  input  logic            pm_we,
  input  logic            pm_wbit,
  input  logic            bp_we,
  input  logic [BP_W-1:0] bp_wdata,
  output logic            npriv,
  output logic            spsel,
  output logic            spsel_nxt,
  output logic            sel_chg,
  output logic            primask,
  output logic [BP_W-1:0] basepri
);
  logic npriv_nxt;

  always_comb begin
    spsel_nxt = spsel;
    npriv_nxt = npriv;
    if (exc_entry) begin
      spsel_nxt = 1'b0;
    end else if (exc_return) begin
      spsel_nxt = ret_sel;
    end else if (ctl_we) begin
      spsel_nxt = ctl_wbits[1];
      npriv_nxt = ctl_wbits[0];
    end
  end

  assign sel_chg = spsel_nxt != spsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spsel   <= 1'b0;
      npriv   <= 1'b0;
      primask <= 1'b0;
      basepri <= '0;
    end else begin
      spsel <= spsel_nxt;
      npriv <= npriv_nxt;
      if (pm_we) primask <= pm_wbit;
      if (bp_we) basepri <= bp_wdata;
    end
  end

  a_r7_entry_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !spsel);
  a_r8_return_loads_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry) |=> (spsel == $past(ret_sel)));
  a_r11_exc_over_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_entry || exc_return) && ctl_we) |=> (npriv == $past(npriv)));
  a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_we |=> $stable(primask));
endmodule

// File: rtl/sr_sp_pair.sv
module sr_sp_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic         sel_cur,
  input  logic         sel_nxt,
  input  logic         gp_we,
  input  logic [W-1:0] gp_wdata,
  input  logic         msp_we,
  input  logic         psp_we,
  input  logic [W-1:0] mv_wdata,
  output logic [W-1:0] act,
  output logic [W-1:0] msp_view,
  output logic [W-1:0] psp_view
);
  logic [W-1:0] bank;
  logic [W-1:0] main_n, proc_n, act_n, bank_n;

  assign msp_view = sel_cur ? bank : act;
  assign psp_view = sel_cur ? act : bank;

  always_comb begin
    main_n = msp_view;
    proc_n = psp_view;
    if (gp_we) begin
      if (sel_cur) proc_n = gp_wdata;
      else         main_n = gp_wdata;
    end
    if (msp_we) main_n = mv_wdata;
    if (psp_we) proc_n = mv_wdata;
    act_n  = sel_nxt ? proc_n : main_n;
    bank_n = sel_nxt ? main_n : proc_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= rst_val;
      bank <= '0;
    end else begin
      act  <= act_n;
      bank <= bank_n;
    end
  end

  a_r4_swap_on_sel_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cur != sel_nxt && !gp_we && !msp_we && !psp_we)
      |=> (act == $past(bank) && bank == $past(act)));
  a_r5_gp_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_we && !msp_we && !psp_we && sel_cur == sel_nxt) |=> (act == $past(gp_wdata)));
endmodule

// File: rtl/sr_rdmux.sv
module sr_rdmux
  import sysreg_pkg::*;
#(
  parameter int W     = 32,
  parameter int NUM_W = 8,
  parameter int BP_W  = 8
) (
  input  logic [NUM_W-1:0] num,
  input  logic [W-1:0]     msp_view,
  input  logic [W-1:0]     psp_view,
  input  logic             npriv,
  input  logic             spsel,
  input  logic             primask,
  input  logic [BP_W-1:0]  basepri,
  output logic [W-1:0]     rdata,
  output logic             known
);
  always_comb begin
    rdata = '0;
    known = 1'b1;
    if (num == NUM_W'(SR_MSP)) begin
      rdata = msp_view;
    end else if (num == NUM_W'(SR_PSP)) begin
      rdata = psp_view;
    end else if (num == NUM_W'(SR_PRIMASK)) begin
      rdata[0] = primask;
    end else if (num == NUM_W'(SR_BASEPRI)) begin
      rdata[BP_W-1:0] = basepri;
    end else if (num == NUM_W'(SR_CONTROL)) begin
      rdata[CTL_NPRIV] = npriv;
      rdata[CTL_SPSEL] = spsel;
      rdata[CTL_FPCA]  = 1'b0;
    end else begin
      known = 1'b0;
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int W     = 32,
  parameter int NUM_W = 8,
  parameter int BP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      sp_reset_val,
  input  logic              mv_valid,
  input  logic              mv_write,
  input  logic [NUM_W-1:0]  mv_num,
  input  logic [W-1:0]      mv_wdata,
  output logic [W-1:0]      mv_rdata,
  output logic              mv_err,
  input  logic              gp_sp_we,
  input  logic [W-1:0]      gp_sp_wdata,
  output logic [W-1:0]      gp_sp_rdata,
  input  logic              exc_entry,
  input  logic              exc_handler,
  input  logic              exc_return,
  input  logic [W-1:0]      exc_ret_link,
  output logic [LINK_W-1:0] link_out
);
  logic wr, known;
  logic msp_we, psp_we, pm_we, bp_we, ctl_we;
  logic npriv, spsel, spsel_nxt, sel_chg, primask;
  logic [BP_W-1:0] basepri;
  logic [W-1:0] msp_view, psp_view;
  logic unused_link_bits;

  assign unused_link_bits = ^{exc_ret_link[W-1:3], exc_ret_link[1:0], sel_chg};

  assign wr     = mv_valid && mv_write;
  assign msp_we = wr && mv_num == NUM_W'(SR_MSP);
  assign psp_we = wr && mv_num == NUM_W'(SR_PSP);
  assign pm_we  = wr && mv_num == NUM_W'(SR_PRIMASK);
  assign bp_we  = wr && mv_num == NUM_W'(SR_BASEPRI);
  assign ctl_we = wr && mv_num == NUM_W'(SR_CONTROL);

  sr_ctrl #(.BP_W(BP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .exc_entry(exc_entry), .exc_return(exc_return), .ret_sel(exc_ret_link[2]),
    .ctl_we(ctl_we), .ctl_wbits(mv_wdata[1:0]),
    .pm_we(pm_we), .pm_wbit(mv_wdata[0]),
    .bp_we(bp_we), .bp_wdata(mv_wdata[BP_W-1:0]),
    .npriv(npriv), .spsel(spsel), .spsel_nxt(spsel_nxt), .sel_chg(sel_chg),
    .primask(primask), .basepri(basepri)
  );

  sr_sp_pair #(.W(W)) u_pair (
    .clk(clk), .rst_n(rst_n), .rst_val(sp_reset_val),
    .sel_cur(spsel), .sel_nxt(spsel_nxt),
    .gp_we(gp_sp_we), .gp_wdata(gp_sp_wdata),
    .msp_we(msp_we), .psp_we(psp_we), .mv_wdata(mv_wdata),
    .act(gp_sp_rdata), .msp_view(msp_view), .psp_view(psp_view)
  );

  sr_rdmux #(.W(W), .NUM_W(NUM_W), .BP_W(BP_W)) u_rd (
    .num(mv_num), .msp_view(msp_view), .psp_view(psp_view),
    .npriv(npriv), .spsel(spsel), .primask(primask), .basepri(basepri),
    .rdata(mv_rdata), .known(known)
  );

  assign link_out = link_value(spsel, exc_handler);

  always_ff @(posedge clk) begin
    if (!rst_n) mv_err <= 1'b0;
    else        mv_err <= mv_valid && !known;
  end

  a_r12_err_after_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    mv_err |-> $past(mv_valid));
  a_r12_unknown_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_write && !known) |-> (mv_rdata == '0));
  a_r6_link_tracks_sel: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |-> (link_out[2] == spsel));
endmodule

// File: tb/sysreg_bank_test.sv
`timescale 1ns/1ps
module sysreg_bank_test;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] sp_reset_val;
  logic mv_valid, mv_write;
  logic [7:0] mv_num;
  logic [W-1:0] mv_wdata, mv_rdata;
  logic mv_err;
  logic gp_sp_we;
  logic [W-1:0] gp_sp_wdata, gp_sp_rdata;
  logic exc_entry, exc_handler, exc_return;
  logic [W-1:0] exc_ret_link;
  logic [31:0] link_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sysreg_bank uut (
    .clk(clk), .rst_n(rst_n), .sp_reset_val(sp_reset_val),
    .mv_valid(mv_valid), .mv_write(mv_write), .mv_num(mv_num),
    .mv_wdata(mv_wdata), .mv_rdata(mv_rdata), .mv_err(mv_err),
    .gp_sp_we(gp_sp_we), .gp_sp_wdata(gp_sp_wdata), .gp_sp_rdata(gp_sp_rdata),
    .exc_entry(exc_entry), .exc_handler(exc_handler), .exc_return(exc_return),
    .exc_ret_link(exc_ret_link), .link_out(link_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int num, output logic [31:0] d);
    @(negedge clk);
    mv_valid = 1; mv_write = 0; mv_num = 8'(num);
    #1 d = mv_rdata;
    @(negedge clk);
    mv_valid = 0;
  endtask

  task automatic wr(input int num, input logic [31:0] v);
    @(negedge clk);
    mv_valid = 1; mv_write = 1; mv_num = 8'(num); mv_wdata = v;
    @(negedge clk);
    mv_valid = 0; mv_write = 0;
  endtask

  task automatic rd_chk(input string tag, input int num, input logic [31:0] exp);
    logic [31:0] d;
    rd(num, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 msp", 8, 32'h2000_1000);
    rd_chk("R1 psp", 9, 0);
    rd_chk("R1 control", 20, 0);
    rd_chk("R1 primask", 16, 0);
    rd_chk("R1 basepri", 17, 0);
    chk("R1 gp", gp_sp_rdata, 32'h2000_1000);
  endtask

  task automatic t_sp_rw;
    wr(9, 32'h3000_0400);
    rd_chk("R3 psp write", 9, 32'h3000_0400);
    rd_chk("R3 msp untouched", 8, 32'h2000_1000);
    chk("R5 gp main active", gp_sp_rdata, 32'h2000_1000);
  endtask

  task automatic t_control;
    wr(20, 32'h7);
    rd_chk("R4 control bits", 20, 32'h3);
    chk("R4 swap to process", gp_sp_rdata, 32'h3000_0400);
    rd_chk("R2 msp banked", 8, 32'h2000_1000);
    rd_chk("R2 psp active", 9, 32'h3000_0400);
    @(negedge clk); gp_sp_we = 1; gp_sp_wdata = 32'h3000_0300;
    @(negedge clk); gp_sp_we = 0;
    rd_chk("R5 gp write process", 9, 32'h3000_0300);
    wr(8, 32'h2000_0F00);
    rd_chk("R3 msp write banked", 8, 32'h2000_0F00);
    chk("R3 active kept", gp_sp_rdata, 32'h3000_0300);
  endtask

  task automatic t_entry;
    @(negedge clk); exc_handler = 0; exc_entry = 1;
    #1 chk("R6 link thread psp", link_out, 32'hFFFF_FFFD);
    @(negedge clk); exc_entry = 0;
    rd_chk("R7 control after entry", 20, 32'h1);
    chk("R7 main active", gp_sp_rdata, 32'h2000_0F00);
    @(negedge clk); exc_handler = 1; exc_entry = 1;
    #1 chk("R6 link handler msp", link_out, 32'hFFFF_FFF1);
    @(negedge clk); exc_entry = 0; exc_handler = 0;
  endtask

  task automatic t_return;
    @(negedge clk); exc_return = 1; exc_ret_link = 32'hFFFF_FFFD;
    @(negedge clk); exc_return = 0;
    rd_chk("R8 control after return", 20, 32'h3);
    chk("R8 process active", gp_sp_rdata, 32'h3000_0300);
    @(negedge clk); exc_return = 1; exc_ret_link = 32'hFFFF_FFF9;
    @(negedge clk); exc_return = 0;
    rd_chk("R8 return to main", 20, 32'h1);
    chk("R8 main active", gp_sp_rdata, 32'h2000_0F00);
  endtask

  task automatic t_priority;
    @(negedge clk); exc_entry = 1; mv_valid = 1; mv_write = 1; mv_num = 20; mv_wdata = 32'h2;
    @(negedge clk); exc_entry = 0; mv_valid = 0; mv_write = 0;
    rd_chk("R11 entry beats control", 20, 32'h1);
    @(negedge clk); exc_return = 1; exc_ret_link = 32'hFFFF_FFFD;
    mv_valid = 1; mv_write = 1; mv_num = 20; mv_wdata = 32'h0;
    @(negedge clk); exc_return = 0; mv_valid = 0; mv_write = 0;
    rd_chk("R11 return beats control", 20, 32'h3);
    @(negedge clk); exc_entry = 1; exc_return = 1; exc_ret_link = 32'hFFFF_FFFD;
    @(negedge clk); exc_entry = 0; exc_return = 0;
    rd_chk("R11 entry beats return", 20, 32'h1);
  endtask

  task automatic t_primask;
    wr(16, 32'hFFFF_FFFE);
    rd_chk("R9 bit0 clear", 16, 0);
    wr(16, 32'h1);
    rd_chk("R9 set", 16, 1);
    wr(16, 32'h3);
    rd_chk("R9 still set", 16, 1);
    wr(16, 32'h2);
    rd_chk("R9 clear", 16, 0);
  endtask

  task automatic t_basepri;
    wr(17, 32'h1234_56A0);
    rd_chk("R10 low bits only", 17, 32'h0000_00A0);
  endtask

  task automatic t_unknown;
    logic [31:0] d;
    rd(5, d);
    chk("R12 unknown reads zero", d, 0);
    chk("R12 err pulse", {31'b0, mv_err}, 1);
    @(negedge clk);
    chk("R12 err one cycle", {31'b0, mv_err}, 0);
    wr(21, 32'hFFFF_FFFF);
    chk("R12 write err pulse", {31'b0, mv_err}, 1);
    rd_chk("R12 control kept", 20, 32'h1);
    chk("R12 no err on known", {31'b0, mv_err}, 0);
    rd_chk("R12 primask kept", 16, 0);
    rd_chk("R12 basepri kept", 17, 32'hA0);
    rd_chk("R12 msp kept", 8, 32'h2000_0F00);
    rd_chk("R12 psp kept", 9, 32'h3000_0300);
  endtask

  initial begin
    rst_n = 0; sp_reset_val = 32'h2000_1000;
    mv_valid = 0; mv_write = 0; mv_num = 0; mv_wdata = 0;
    gp_sp_we = 0; gp_sp_wdata = 0;
    exc_entry = 0; exc_handler = 0; exc_return = 0; exc_ret_link = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset;
    t_sp_rw;
    t_control;
    t_entry;
    t_return;
    t_priority;
    t_primask;
    t_basepri;
    t_unknown;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule